// File: doc/BRIEF.md
# APB requester transfer sequencer

This block is the requester end of a peripheral bus with a single select line. Commands arrive on a valid/ready port as an address, a direction bit and, for writes, a data word. Each accepted command becomes one two-phase bus transfer. First comes a one-cycle setup phase with select high and enable low. Then comes an access phase with enable high, which lasts until the completer raises its ready input. Every bus output comes straight from a flop.

When a transfer completes, the block raises a response strobe for exactly one cycle. The strobe carries the read data that was captured and the completer's error bit. A write reports zero read data. The command port accepts only when the controller is idle, or on the cycle in which the running transfer completes, so at most one command is held at a time. A command accepted on a completing cycle follows at once: the controller goes straight from access back into setup, and select does not drop.

Reset is asynchronous and active low. Its release is synchronised internally, so the command port stays closed for two cycles after reset is removed.

Top module: `apb_xfer_seq`

## Requirements
- R1: After reset has been released and the synchroniser has settled, `bus_sel`, `bus_enable` and `rsp_valid` are 0 and `cmd_ready` is 1.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `bus_sel` is 1, `bus_enable` is 0, and `bus_addr`, `bus_write` and `bus_wdata` equal the accepted command (`bus_write` = 1 means write).
- R3: The setup phase (`bus_sel` 1, `bus_enable` 0) lasts exactly one cycle. The next cycle is an access phase (`bus_sel` 1, `bus_enable` 1) with address, direction and write data unchanged.
- R4: `bus_enable` is never 1 while `bus_sel` is 0.
- R5: In an access cycle where `bus_ready` is 0, the next cycle is again an access cycle, with `bus_addr`, `bus_write` and `bus_wdata` unchanged. Any number of such wait cycles is allowed.
- R6: The transfer completes in an access cycle where `bus_ready` is 1. If no command is accepted in that cycle, the next cycle has `bus_sel` 0 and `bus_enable` 0.
- R7: If a command is accepted in a completing cycle, the next cycle is a setup phase for the new command, with `bus_sel` still 1.
- R8: `cmd_ready` is 1 only when the controller is idle (`bus_sel` 0), or when it is in an access cycle with `bus_ready` 1.
- R9: `rsp_valid` is 1 for exactly one cycle, in the cycle after each completion and at no other time, so there is one strobe per accepted command, delivered in order.
- R10: For a read, `rsp_rdata` equals the `bus_rdata` value present on the completing cycle. Values driven during wait cycles are not captured. For a write, `rsp_rdata` is 0.
- R11: `rsp_err` equals the `bus_err` value on the completing cycle, for reads and for writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The command is taken on this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW (32) | Transfer address |
| cmd_wdata | input | DW (32) | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DW (32) | Captured read data, 0 for writes |
| rsp_err | output | 1 | Completer error for the transfer |
| bus_sel | output | 1 | Completer select |
| bus_enable | output | 1 | Access-phase enable |
| bus_write | output | 1 | Transfer direction |
| bus_addr | output | AW (32) | Bus address |
| bus_wdata | output | DW (32) | Bus write data |
| bus_ready | input | 1 | Completer ready, ends the access phase |
| bus_rdata | input | DW (32) | Completer read data |
| bus_err | input | 1 | Completer error flag |

## Verification
The checker watches every cycle for the following properties:
- the phase order and the single-cycle setup;
- enable never high without select;
- bus signals held still through wait cycles;
- select falling or staying high at a completion, according to whether a new command was taken;
- the gating of `cmd_ready`;
- the one-cycle response strobe, with its captured data and error bit.

Only the bench's scenarios can show the rest. Responses must come back one per command and in order. Read data must match what an earlier write stored, across wait counts from zero to three. Garbage driven on the read-data lines during wait cycles must never be captured. Finally, the port must be open after reset.

// File: rtl/apb_seq_pkg.sv
package apb_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } seq_state_e;
endpackage

// File: rtl/apb_rst_sync.sv
module apb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/apb_seq_fsm.sv
module apb_seq_fsm
  import apb_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic bus_ready,
  output logic cmd_ready,
  output logic load,
  output logic done,
  output logic sel_q,
  output logic en_q
);
  seq_state_e state_q, state_d;

  // the port is open only in idle, or on the completing access cycle
  assign done      = (state_q == ST_ACCESS) && bus_ready;
  assign cmd_ready = rst_n && ((state_q == ST_IDLE) || done);
  assign load      = cmd_valid && cmd_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (load) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (bus_ready) state_d = load ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= (state_d != ST_IDLE);
      en_q    <= (state_d == ST_ACCESS);
    end
  end
endmodule

// File: rtl/apb_seq_hold.sv
module apb_seq_hold #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          write_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      write_q <= cmd_write;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end
  end
endmodule

// File: rtl/apb_seq_rsp.sv
module apb_seq_rsp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          write_q,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err
);
  logic [DW-1:0] rdata_d;

  assign rdata_d = write_q ? '0 : bus_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (done) begin
      rsp_rdata <= rdata_d;
      rsp_err   <= bus_err;
    end
  end
endmodule

// File: rtl/apb_xfer_seq.sv
module apb_xfer_seq #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          bus_sel,
  output logic          bus_enable,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err
);
  logic rst_n_int;
  logic load;
  logic done;

  apb_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  apb_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_valid (cmd_valid),
    .bus_ready (bus_ready),
    .cmd_ready (cmd_ready),
    .load      (load),
    .done      (done),
    .sel_q     (bus_sel),
    .en_q      (bus_enable)
  );

  apb_seq_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (load),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .write_q   (bus_write),
    .addr_q    (bus_addr),
    .wdata_q   (bus_wdata)
  );

  apb_seq_rsp #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .done      (done),
    .write_q   (bus_write),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/apb_xfer_seq_chk.sv
module apb_xfer_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_wdata,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic          bus_sel,
  input logic          bus_enable,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_err
);
  logic take, finish;
  assign take   = cmd_valid && cmd_ready;
  assign finish = bus_enable && bus_ready;

  // R2
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (bus_sel && !bus_enable && bus_addr == $past(cmd_addr)
              && bus_write == $past(cmd_write) && bus_wdata == $past(cmd_wdata)));

  // R3
  setup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_enable) |=> (bus_sel && bus_enable && $stable(bus_addr)
                                  && $stable(bus_write) && $stable(bus_wdata)));

  // R4
  enable_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_enable |-> bus_sel);

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_enable && !bus_ready) |=> (bus_sel && bus_enable && $stable(bus_addr)
                                    && $stable(bus_write) && $stable(bus_wdata)));

  // R6
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !take) |=> (!bus_sel && !bus_enable));

  // R7
  chain_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && take) |=> (bus_sel && !bus_enable));

  // R8
  port_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_sel || finish));

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> rsp_valid);

  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> !rsp_valid);

  // R10
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !bus_write) |=> (rsp_rdata == $past(bus_rdata)));

  // R10
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && bus_write) |=> (rsp_rdata == '0));

  // R11
  err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (rsp_err == $past(bus_err)));
endmodule

bind apb_xfer_seq apb_xfer_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/apb_xfer_seq_test.sv
module apb_xfer_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        cmd_write;
  logic [31:0] cmd_addr;
  logic [31:0] cmd_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        bus_sel;
  logic        bus_enable;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        bus_err;

  apb_xfer_seq uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  int checks = 0;
  int failures = 0;
  int issued = 0;
  int responses = 0;
  bit mon_on = 0;

  logic [32:0] exp_q[$];
  logic [31:0] shadow [16];
  logic [31:0] cmem [16];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Driver: predicts the response, then offers the command until it is taken.
  task automatic issue(input logic w, input logic [31:0] a, input logic [31:0] d);
    if (w) begin
      shadow[a[5:2]] = d;
      exp_q.push_back({a[31], 32'h0});
    end else begin
      exp_q.push_back({a[31], shadow[a[5:2]]});
    end
    issued++;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = w;
    cmd_addr  = a;
    cmd_wdata = d;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Completer model: the wait count is addr[9:8], the error is addr[31], and
  // garbage is driven on the read lines while waiting.
  int wcnt = 0;
  always @(negedge clk) begin
    if (bus_sel && bus_enable) begin
      if (wcnt == int'(bus_addr[9:8])) begin
        bus_ready = 1'b1;
        bus_err   = bus_addr[31];
        bus_rdata = bus_write ? 32'hDEAD_BEEF : cmem[bus_addr[5:2]];
        if (bus_write) cmem[bus_addr[5:2]] = bus_wdata;
        wcnt = 0;
      end else begin
        bus_ready = 1'b0;
        bus_err   = 1'b1;
        bus_rdata = 32'h0BAD_0000 | wcnt;
        wcnt++;
      end
    end else begin
      bus_ready = 1'b0;
      bus_err   = 1'b0;
      bus_rdata = 32'hFFFF_FFFF;
      wcnt = 0;
    end
  end

  // Monitor: compares each cycle with the previous one and pops the scoreboard.
  logic        p_sel = 0, p_en = 0, p_rdy = 0, p_take = 0, p_w = 0, p_cw = 0;
  logic [31:0] p_a = 0, p_d = 0, p_ca = 0, p_cd = 0;
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      if (p_take)
        // R2 R7
        check(bus_sel && !bus_enable && bus_addr == p_ca && bus_wdata == p_cd
              && bus_write == p_cw, "R2/R7 setup after accept",
              {bus_sel, bus_enable, bus_addr}, {2'b10, p_ca});
      else if (p_sel && !p_en)
        // R3
        check(bus_sel && bus_enable && bus_addr == p_a && bus_wdata == p_d
              && bus_write == p_w, "R3 access after setup",
              {bus_sel, bus_enable, bus_addr}, {2'b11, p_a});
      else if (p_en && !p_rdy)
        // R5
        check(bus_sel && bus_enable && bus_addr == p_a && bus_wdata == p_d
              && bus_write == p_w, "R5 wait hold",
              {bus_sel, bus_enable, bus_addr}, {2'b11, p_a});
      else if (p_en && p_rdy)
        // R6
        check(!bus_sel && !bus_enable, "R6 idle after completion",
              {bus_sel, bus_enable}, 2'b00);
      // R4
      check(!bus_enable || bus_sel, "R4 enable implies select",
            {bus_sel, bus_enable}, 2'b11);
      // R8
      check(cmd_ready == (!bus_sel || (bus_enable && bus_ready)), "R8 port gate",
            cmd_ready, !bus_sel || (bus_enable && bus_ready));
      // R9
      check(rsp_valid == (p_en && p_rdy), "R9 strobe timing", rsp_valid, p_en && p_rdy);
      if (rsp_valid) begin
        responses++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected response", 1, 0);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          // R10
          check(rsp_rdata == e[31:0], "R10 read data", rsp_rdata, e[31:0]);
          // R11
          check(rsp_err == e[32], "R11 error flag", rsp_err, e[32]);
        end
      end
    end
    p_sel  = bus_sel;   p_en = bus_enable; p_rdy = bus_ready;
    p_take = cmd_valid && cmd_ready;
    p_a    = bus_addr;  p_d  = bus_wdata;  p_w   = bus_write;
    p_ca   = cmd_addr;  p_cd = cmd_wdata;  p_cw  = cmd_write;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      shadow[i] = 32'h0;
      cmem[i]   = 32'h0;
    end
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    bus_ready = 1'b0; bus_rdata = '0; bus_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    // R1
    check(!bus_sel && !bus_enable && !rsp_valid && cmd_ready, "R1 reset state",
          {bus_sel, bus_enable, rsp_valid, cmd_ready}, 4'b0001);
    mon_on = 1'b1;

    // single transfers, no wait and with waits
    issue(1'b1, 32'h0000_0004, 32'h1111_2222); drop();
    repeat (3) @(negedge clk);
    issue(1'b0, 32'h0000_0004, 32'h0);         drop();
    repeat (3) @(negedge clk);
    issue(1'b1, 32'h0000_0308, 32'hA5A5_0001); drop();   // 3 waits
    repeat (6) @(negedge clk);
    issue(1'b0, 32'h0000_0208, 32'h0);         drop();   // 2 waits, garbage on bus
    repeat (6) @(negedge clk);

    // back-to-back chain with mixed waits
    issue(1'b1, 32'h0000_0110, 32'hCAFE_0010);
    issue(1'b1, 32'h0000_0014, 32'hCAFE_0014);
    issue(1'b0, 32'h0000_0310, 32'h0);
    issue(1'b0, 32'h0000_0014, 32'h0);
    issue(1'b0, 32'h0000_0104, 32'h0);
    drop();
    repeat (8) @(negedge clk);

    // error responses for write and read
    issue(1'b1, 32'h8000_0118, 32'h0BAD_F00D);
    issue(1'b0, 32'h8000_0018, 32'h0);
    drop();
    repeat (6) @(negedge clk);
    issue(1'b0, 32'h0000_0018, 32'h0); drop();
    repeat (8) @(negedge clk);

    // R9 one response per command
    check(responses == issued && exp_q.size() == 0, "R9 response count",
          responses, issued);
    summary();
    $finish;
  end
endmodule